// File: doc/BRIEF.md
# Pending Store Buffer with Load Forwarding and Ordering Fence

This block sits between a processor core's store path and a memory write port. Every store from the core is captured in a small circular queue, so the core can move on while memory accepts writes at its own pace. The oldest queued store is offered on a ready/valid write port, and it leaves the queue on each accepted handshake. A load from the core looks up its address among the queued stores and gets the data at once. If several queued stores match, the youngest one supplies the data. If none matches, the core reads memory itself without waiting for the queue to empty.

A mode input selects between two drain disciplines. In strict mode the queue is a pure FIFO: every store is written to memory in acceptance order, and repeated stores to one address are all kept. In relaxed mode a new store whose address matches a queued entry overwrites that entry in place, provided the entry is not the one currently offered to memory. No new slot is used, so the merged value becomes visible ahead of stores that were issued earlier.

A fence request stalls the core until the queue is empty, then gives a one-cycle completion pulse. An atomic request also stalls the core and waits for the queue to drain. It is then presented on the memory port, flagged as atomic, without ever entering the queue.

Top module: `store_queue`

## Requirements
- R1: After synchronous reset the queue is empty (`buf_empty`=1), `mem_valid`=0, `core_stall`=0, `fence_done`=0 and `st_ready`=1.
- R2: A store accepted at a clock edge is held in the queue and appears on the memory write port (`mem_valid`=1 with its address and data) from the following cycle, never in the same cycle.
- R3: When `ld_valid`=1 and `ld_addr` equals the address of a queued store, `ld_hit`=1 and `ld_data` carries that store's data in the same cycle. When no queued store matches, `ld_hit`=0.
- R4: When several queued stores match a load address, `ld_data` returns the data of the most recently accepted one.
- R5: With `relaxed_order`=0, stores are written to memory in exactly their acceptance order, and a store to an address already queued takes a new entry.
- R6: With `relaxed_order`=1, a store whose address matches a queued entry other than the head entry overwrites that entry's data and takes no new slot. A match on the head entry takes a new slot instead.
- R7: When all DEPTH entries are occupied and no merge applies, `st_ready`=0. The held store is accepted after an entry drains, and no store is lost or duplicated.
- R8: A load lookup needs no drain: while the queue is full and memory is not accepting, a miss reports `ld_hit`=0 and a hit returns its data in the same cycle.
- R9: After a one-cycle `fence_req`, `core_stall`=1 and `st_ready`=0 until completion. `fence_done` pulses for one cycle in the cycle after the first cycle in which `buf_empty`=1, and `core_stall` is 0 in that cycle.
- R10: After a one-cycle `at_req`, the core is stalled and every queued store is written first. The atomic address and data are then offered with `mem_atomic`=1, and `at_done`=1 in the cycle of its handshake.
- R11: While `mem_valid`=1 and `mem_ready`=0, the offered `mem_addr` and `mem_data` do not change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| relaxed_order | input | 1 | 0: strict FIFO drain; 1: same-address merging allowed |
| st_valid | input | 1 | Core store request |
| st_addr | input | AW | Store address |
| st_data | input | DW | Store data |
| st_ready | output | 1 | Store accepted this cycle when high with st_valid |
| ld_valid | input | 1 | Core load lookup |
| ld_addr | input | AW | Load address |
| ld_hit | output | 1 | Load address matches a queued store |
| ld_data | output | DW | Forwarded data of the youngest match |
| fence_req | input | 1 | One-cycle fence request |
| fence_done | output | 1 | One-cycle fence completion |
| at_req | input | 1 | One-cycle atomic request |
| at_addr | input | AW | Atomic address |
| at_data | input | DW | Atomic data |
| at_done | output | 1 | Atomic accepted by memory |
| core_stall | output | 1 | Core must hold further operations |
| buf_empty | output | 1 | No queued stores |
| mem_valid | output | 1 | Memory write offered |
| mem_ready | input | 1 | Memory accepts the write |
| mem_addr | output | AW | Memory write address |
| mem_data | output | DW | Memory write data |
| mem_atomic | output | 1 | Offered write is the atomic operation |

## Verification
Forwarding is tried with three stores, two of them to the same address, while memory back-pressures. This separates "any match" from "youngest match" and shows that a miss is not confused with a hit. The same store sequence is drained in both modes. In strict mode every duplicate must reach memory in order. In relaxed mode a non-head match must be absorbed and reordered, and a head match must still take a fresh slot. Separate tests fill the queue under back-pressure and then issue a fence and an atomic behind queued stores. These show that loads never wait, that a full queue blocks without losing data, and that the completion pulse and the atomic write come only after the last queued store.

// File: rtl/stq_pkg.sv
// Shared types for the pending store buffer.
package stq_pkg;
    // Control sequencer states for fence and atomic handling.
    typedef enum logic [2:0] {
        CTL_IDLE   = 3'd0,
        CTL_FENCE  = 3'd1,
        CTL_FDONE  = 3'd2,
        CTL_ADRAIN = 3'd3,
        CTL_AISSUE = 3'd4
    } ctl_state_e;
endpackage

// File: rtl/stq_entries.sv
// Circular storage of pending stores.
// Assumes DEPTH is a power of two (at least 2) so that the pointers wrap
// naturally. It supports a push at the tail, an in-place data overwrite
// (merge) at any index, and a pop at the head, all in the same cycle.
module stq_entries #(
    parameter int DEPTH = 4,
    parameter int AW    = 16,
    parameter int DW    = 32,
    localparam int PW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     push,
    input  logic                     merge,
    input  logic [PW-1:0]            merge_idx,
    input  logic [AW-1:0]            wr_addr,
    input  logic [DW-1:0]            wr_data,
    input  logic                     pop,
    output logic [DEPTH-1:0][AW-1:0] ent_addr,
    output logic [DEPTH-1:0][DW-1:0] ent_data,
    output logic [PW-1:0]            head,
    output logic [CW-1:0]            count,
    output logic                     full,
    output logic                     empty
);
    logic [PW-1:0] tail;

    // Pointer and occupancy bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head  <= '0;
            tail  <= '0;
            count <= '0;
        end else begin
            if (push) tail <= tail + 1'b1;
            if (pop)  head <= head + 1'b1;
            count <= count + CW'(push) - CW'(pop);
        end
    end

    // Entry payload writes: a new slot on push, or a data overwrite on merge.
    always_ff @(posedge clk) begin
        if (push) begin
            ent_addr[tail] <= wr_addr;
            ent_data[tail] <= wr_data;
        end
        if (merge) ent_data[merge_idx] <= wr_data;
    end

    assign full  = (count == CW'(DEPTH));
    assign empty = (count == '0);

    p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> (count < CW'(DEPTH)));
    p_no_underflow_r2: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> (count != '0));
    p_merge_not_head_r6: assert property (@(posedge clk) disable iff (!rst_n)
        merge |-> (merge_idx != head));
endmodule

// File: rtl/stq_match.sv
// Address search over the occupied entries.
// It walks from the oldest to the youngest entry, and a later match overrides
// an earlier one, so the reported index is that of the youngest match.
module stq_match #(
    parameter int DEPTH = 4,
    parameter int AW    = 16,
    localparam int PW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic [DEPTH-1:0][AW-1:0] ent_addr,
    input  logic [PW-1:0]            head,
    input  logic [CW-1:0]            count,
    input  logic [AW-1:0]            q_addr,
    output logic                     hit,
    output logic [PW-1:0]            idx
);
    logic [PW-1:0] pos;

    // Priority search, with the youngest occupied match winning.
    always_comb begin
        hit = 1'b0;
        idx = head;
        pos = head;
        for (int k = 0; k < DEPTH; k++) begin
            pos = head + PW'(k);
            if ((CW'(k) < count) && (ent_addr[pos] == q_addr)) begin
                hit = 1'b1;
                idx = pos;
            end
        end
    end
endmodule

// File: rtl/stq_ctrl.sv
// Fence and atomic sequencer.
// It assumes that fence_req and at_req are single-cycle pulses and are never
// raised together; if they are, the atomic request takes priority. New
// requests are taken only while the core is not stalled.
module stq_ctrl #(
    parameter int AW = 16,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fence_req,
    input  logic          at_req,
    input  logic [AW-1:0] at_addr,
    input  logic [DW-1:0] at_data,
    input  logic          buf_empty,
    input  logic          mem_ready,
    output logic          stall,
    output logic          fence_done,
    output logic          at_issue,
    output logic          at_done,
    output logic [AW-1:0] at_addr_q,
    output logic [DW-1:0] at_data_q
);
    import stq_pkg::*;
    ctl_state_e state;
    logic       open_st;

    assign open_st = (state == CTL_IDLE) || (state == CTL_FDONE);

    // State sequencing and capture of the atomic operands.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= CTL_IDLE;
            at_addr_q <= '0;
            at_data_q <= '0;
        end else begin
            case (state)
                CTL_FENCE:  if (buf_empty) state <= CTL_FDONE;
                CTL_ADRAIN: if (buf_empty) state <= CTL_AISSUE;
                CTL_AISSUE: if (mem_ready) state <= CTL_IDLE;
                default: begin
                    if (at_req) begin
                        state     <= CTL_ADRAIN;
                        at_addr_q <= at_addr;
                        at_data_q <= at_data;
                    end else if (fence_req) begin
                        state <= CTL_FENCE;
                    end else begin
                        state <= CTL_IDLE;
                    end
                end
            endcase
        end
    end

    assign stall      = !open_st;
    assign fence_done = (state == CTL_FDONE);
    assign at_issue   = (state == CTL_AISSUE);
    assign at_done    = at_issue && mem_ready;

    p_fence_after_empty_r9: assert property (@(posedge clk) disable iff (!rst_n)
        fence_done |-> $past(buf_empty));
    p_atomic_on_empty_r10: assert property (@(posedge clk) disable iff (!rst_n)
        at_issue |-> buf_empty);
endmodule

// File: rtl/store_queue.sv
// Pending store buffer top.
// It queues core stores, forwards the youngest matching data to loads,
// drains the oldest entry to a ready/valid write port, and sequences fences
// and atomics. In relaxed mode it merges a store into a matching non-head
// entry. It assumes the core honours core_stall and st_ready.
module store_queue #(
    parameter int DEPTH = 4,
    parameter int AW    = 16,
    parameter int DW    = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          relaxed_order,
    input  logic          st_valid,
    input  logic [AW-1:0] st_addr,
    input  logic [DW-1:0] st_data,
    output logic          st_ready,
    input  logic          ld_valid,
    input  logic [AW-1:0] ld_addr,
    output logic          ld_hit,
    output logic [DW-1:0] ld_data,
    input  logic          fence_req,
    output logic          fence_done,
    input  logic          at_req,
    input  logic [AW-1:0] at_addr,
    input  logic [DW-1:0] at_data,
    output logic          at_done,
    output logic          core_stall,
    output logic          buf_empty,
    output logic          mem_valid,
    input  logic          mem_ready,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_data,
    output logic          mem_atomic
);
    localparam int PW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);

    logic [DEPTH-1:0][AW-1:0] ent_addr;
    logic [DEPTH-1:0][DW-1:0] ent_data;
    logic [PW-1:0]            head, st_idx, ld_idx;
    logic [CW-1:0]            count;
    logic                     full, st_hit, ld_match, merge_ok;
    logic                     accept, push, merge, pop, at_issue;
    logic [AW-1:0]            at_addr_q;
    logic [DW-1:0]            at_data_q;

    stq_entries #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_entries (
        .clk(clk), .rst_n(rst_n), .push(push), .merge(merge),
        .merge_idx(st_idx), .wr_addr(st_addr), .wr_data(st_data), .pop(pop),
        .ent_addr(ent_addr), .ent_data(ent_data), .head(head),
        .count(count), .full(full), .empty(buf_empty)
    );

    stq_match #(.DEPTH(DEPTH), .AW(AW)) u_st_match (
        .ent_addr(ent_addr), .head(head), .count(count),
        .q_addr(st_addr), .hit(st_hit), .idx(st_idx)
    );

    stq_match #(.DEPTH(DEPTH), .AW(AW)) u_ld_match (
        .ent_addr(ent_addr), .head(head), .count(count),
        .q_addr(ld_addr), .hit(ld_match), .idx(ld_idx)
    );

    stq_ctrl #(.AW(AW), .DW(DW)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .fence_req(fence_req), .at_req(at_req),
        .at_addr(at_addr), .at_data(at_data), .buf_empty(buf_empty),
        .mem_ready(mem_ready), .stall(core_stall), .fence_done(fence_done),
        .at_issue(at_issue), .at_done(at_done),
        .at_addr_q(at_addr_q), .at_data_q(at_data_q)
    );

    // Store intake: merge into a non-head match in relaxed mode, else take a slot.
    always_comb begin
        merge_ok = relaxed_order && st_hit && (st_idx != head);
        st_ready = !core_stall && (merge_ok || !full);
        accept   = st_valid && st_ready;
        push     = accept && !merge_ok;
        merge    = accept && merge_ok;
    end

    // Memory port: the atomic operand when issuing, else the head entry.
    always_comb begin
        mem_atomic = at_issue;
        mem_valid  = at_issue || !buf_empty;
        mem_addr   = at_issue ? at_addr_q : ent_addr[head];
        mem_data   = at_issue ? at_data_q : ent_data[head];
        pop        = !at_issue && !buf_empty && mem_ready;
    end

    // Load forwarding from the youngest matching entry.
    always_comb begin
        ld_hit  = ld_valid && ld_match;
        ld_data = ld_hit ? ent_data[ld_idx] : '0;
    end

    p_hold_head_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_data)));
    p_stall_blocks_r9: assert property (@(posedge clk) disable iff (!rst_n)
        core_stall |-> !st_ready);
    p_hit_needs_entry_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ld_hit |-> !buf_empty);
endmodule

// File: tb/store_queue_test.sv
`timescale 1ns/1ps
module store_queue_test;
    localparam int AW = 16;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          relaxed_order = 1'b0;
    logic          st_valid = 1'b0;
    logic [AW-1:0] st_addr = '0;
    logic [DW-1:0] st_data = '0;
    logic          st_ready;
    logic          ld_valid = 1'b0;
    logic [AW-1:0] ld_addr = '0;
    logic          ld_hit;
    logic [DW-1:0] ld_data;
    logic          fence_req = 1'b0;
    logic          fence_done;
    logic          at_req = 1'b0;
    logic [AW-1:0] at_addr = '0;
    logic [DW-1:0] at_data = '0;
    logic          at_done, core_stall, buf_empty;
    logic          mem_valid;
    logic          mem_ready = 1'b0;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_data;
    logic          mem_atomic;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    logic [AW-1:0] lg_a [64];
    logic [DW-1:0] lg_d [64];
    logic          lg_t [64];
    int            log_n = 0;

    always #2 clk = ~clk;

    store_queue #(.DEPTH(4), .AW(AW), .DW(DW)) uut (
        .clk(clk), .rst_n(rst_n), .relaxed_order(relaxed_order),
        .st_valid(st_valid), .st_addr(st_addr), .st_data(st_data), .st_ready(st_ready),
        .ld_valid(ld_valid), .ld_addr(ld_addr), .ld_hit(ld_hit), .ld_data(ld_data),
        .fence_req(fence_req), .fence_done(fence_done),
        .at_req(at_req), .at_addr(at_addr), .at_data(at_data), .at_done(at_done),
        .core_stall(core_stall), .buf_empty(buf_empty),
        .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_addr(mem_addr),
        .mem_data(mem_data), .mem_atomic(mem_atomic)
    );

    // Memory model: record every accepted write in order.
    always @(posedge clk) begin
        if (rst_n && mem_valid && mem_ready && log_n < 64) begin
            lg_a[log_n] <= mem_addr;
            lg_d[log_n] <= mem_data;
            lg_t[log_n] <= mem_atomic;
            log_n <= log_n + 1;
        end
    end

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic eq(input string tag, input logic [63:0] act, input logic [63:0] exp);
        check(act === exp, tag, act, exp);
    endtask

    // Offer one store and hold it until accepted.
    task automatic put(input logic [AW-1:0] a, input logic [DW-1:0] d);
        bit rdy;
        @(negedge clk);
        st_valid = 1'b1; st_addr = a; st_data = d;
        for (int g = 0; g < 100; g++) begin
            #0.5;
            rdy = st_ready;
            @(negedge clk);
            if (rdy) break;
        end
        st_valid = 1'b0;
    endtask

    // Let memory accept until the queue is empty.
    task automatic drain();
        mem_ready = 1'b1;
        for (int g = 0; g < 60; g++) begin
            @(negedge clk);
            if (buf_empty && !mem_valid) break;
        end
        mem_ready = 1'b0;
    endtask

    task automatic chk_log(input int i, input logic [AW-1:0] a, input logic [DW-1:0] d,
                           input logic t, input string tag);
        eq({tag, " addr"}, lg_a[i], a);
        eq({tag, " data"}, lg_d[i], d);
        eq({tag, " atomic"}, lg_t[i], t);
    endtask

    task automatic t_reset();
        @(negedge clk);
        eq("R1 buf_empty", buf_empty, 1);
        eq("R1 mem_valid", mem_valid, 0);
        eq("R1 core_stall", core_stall, 0);
        eq("R1 fence_done", fence_done, 0);
        eq("R1 st_ready", st_ready, 1);
    endtask

    task automatic t_forward_strict();
        int base;
        base = log_n;
        relaxed_order = 1'b0; mem_ready = 1'b0;
        put(16'h0010, 32'h11);
        eq("R2 mem_valid after accept", mem_valid, 1);
        eq("R2 mem_addr head", mem_addr, 16'h0010);
        put(16'h0020, 32'h22);
        put(16'h0010, 32'h33);
        eq("R11 head addr held", mem_addr, 16'h0010);
        eq("R11 head data held", mem_data, 32'h11);
        ld_valid = 1'b1; ld_addr = 16'h0010; #0.5;
        eq("R4 youngest hit", ld_hit, 1);
        eq("R4 youngest data", ld_data, 32'h33);
        ld_addr = 16'h0020; #0.5;
        eq("R3 hit data", ld_data, 32'h22);
        ld_addr = 16'h0030; #0.5;
        eq("R3 miss", ld_hit, 0);
        ld_valid = 1'b0;
        drain();
        eq("R5 write count", log_n - base, 3);
        chk_log(base,     16'h0010, 32'h11, 0, "R5 first");
        chk_log(base + 1, 16'h0020, 32'h22, 0, "R5 second");
        chk_log(base + 2, 16'h0010, 32'h33, 0, "R5 third");
    endtask

    task automatic t_merge_relaxed();
        int base;
        base = log_n;
        relaxed_order = 1'b1; mem_ready = 1'b0;
        put(16'h0040, 32'h1);
        put(16'h0050, 32'h2);
        put(16'h0060, 32'h5);
        put(16'h0050, 32'h3);
        put(16'h0040, 32'h4);
        ld_valid = 1'b1; ld_addr = 16'h0050; #0.5;
        eq("R6 merged load", ld_data, 32'h3);
        ld_valid = 1'b0;
        drain();
        eq("R6 write count", log_n - base, 4);
        chk_log(base,     16'h0040, 32'h1, 0, "R6 w0");
        chk_log(base + 1, 16'h0050, 32'h3, 0, "R6 w1 merged");
        chk_log(base + 2, 16'h0060, 32'h5, 0, "R6 w2");
        chk_log(base + 3, 16'h0040, 32'h4, 0, "R6 w3 head match");
        relaxed_order = 1'b0;
    endtask

    task automatic t_full();
        int base;
        base = log_n;
        mem_ready = 1'b0;
        for (int i = 1; i <= 4; i++) put(AW'(16'h0090 + i), DW'(32'h100 + i));
        @(negedge clk);
        st_valid = 1'b1; st_addr = 16'h0095; st_data = 32'h105; #0.5;
        eq("R7 full blocks", st_ready, 0);
        ld_valid = 1'b1; ld_addr = 16'h0099; #0.5;
        eq("R8 miss while full", ld_hit, 0);
        ld_addr = 16'h0091; #0.5;
        eq("R8 hit while full", ld_data, 32'h101);
        ld_valid = 1'b0;
        st_valid = 1'b0;
        mem_ready = 1'b1;
        put(16'h0095, 32'h105);
        drain();
        eq("R7 write count", log_n - base, 5);
        for (int i = 0; i < 5; i++)
            chk_log(base + i, AW'(16'h0091 + i), DW'(32'h101 + i), 0, "R7 order");
    endtask

    task automatic t_fence();
        int base;
        bit prev_empty, seen;
        base = log_n;
        mem_ready = 1'b0;
        put(16'h00a0, 32'ha);
        put(16'h00a1, 32'hb);
        fence_req = 1'b1;
        @(negedge clk);
        fence_req = 1'b0;
        st_valid = 1'b1; st_addr = 16'h00a2; #0.5;
        eq("R9 stall", core_stall, 1);
        eq("R9 st blocked", st_ready, 0);
        st_valid = 1'b0;
        mem_ready = 1'b1;
        prev_empty = buf_empty;
        seen = 0;
        for (int g = 0; g < 30; g++) begin
            @(negedge clk);
            if (fence_done) begin
                seen = 1;
                eq("R9 empty before done", prev_empty, 1);
                eq("R9 drained before done", log_n - base, 2);
                eq("R9 released", core_stall, 0);
                break;
            end
            eq("R9 stall held", core_stall, 1);
            prev_empty = buf_empty;
        end
        eq("R9 done seen", seen, 1);
        @(negedge clk);
        eq("R9 single pulse", fence_done, 0);
        mem_ready = 1'b0;
    endtask

    task automatic t_atomic();
        int base;
        bit seen;
        base = log_n;
        mem_ready = 1'b0;
        put(16'h00b0, 32'hc);
        put(16'h00b1, 32'hd);
        at_req = 1'b1; at_addr = 16'h0070; at_data = 32'h77;
        @(negedge clk);
        at_req = 1'b0;
        eq("R10 stall", core_stall, 1);
        mem_ready = 1'b1;
        seen = 0;
        for (int g = 0; g < 30; g++) begin
            @(negedge clk);
            if (mem_valid && mem_atomic) begin
                seen = 1;
                eq("R10 drained first", log_n - base, 2);
                eq("R10 at_done", at_done, 1);
                eq("R10 atomic addr", mem_addr, 16'h0070);
                break;
            end
        end
        eq("R10 atomic seen", seen, 1);
        @(negedge clk);
        mem_ready = 1'b0;
        eq("R10 write count", log_n - base, 3);
        chk_log(base + 2, 16'h0070, 32'h77, 1, "R10 atomic");
        eq("R10 released", core_stall, 0);
    endtask

    initial begin
        #(4 * 100000);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_forward_strict();
        t_merge_relaxed();
        t_full();
        t_fence();
        t_atomic();
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule